// File: doc/BRIEF.md
# BCH Error Location Bit Flipper

This block repairs a 512-byte data sector after a BCH decoder has found where the bit errors are. It keeps the sector in a local byte RAM. A host loads the RAM through a simple byte port, then hands the block a list of up to eight error bit locations and a start strobe. The block walks the list and turns each location into a byte address and a single-bit mask. It then inverts that bit with a read-modify-write of the RAM. When the list is finished it raises a one-cycle done pulse, and the host reads the repaired sector back through the same byte port.

The locator numbers the bits of each codeword with the parity bits first. The data bits follow in reverse order. The parity bit count is four times the parameter `NIBBLES` (13, 26 or 52 for strengths 4, 8 and 16). A location that falls in the parity region is dropped. A location that falls past the end of the sector is dropped as well. The control pins are plain level and pulse signals. There is no back-pressure: the host must not start a new list while `busy` is high. While `busy` is high the engine owns the RAM port.

Top module: `bch_err_flipper`

## Requirements
- R1: During reset and directly after it, `busy`, `done` and `host_rd_data` are all 0.
- R2: A location L with L < 4*NIBBLES (at most 103 with the default of 26) lies in the parity region and changes no RAM byte.
- R3: For a location L ≥ 4*NIBBLES, let A = L − 4*NIBBLES. When A < 4096, byte (4095 − A) / 8 has bit (A mod 8) inverted. With the default, location 104 inverts bit 0 of byte 511 and location 4199 inverts bit 7 of byte 0.
- R4: A location whose adjusted value A is 4096 or more (4200 or more with the default) changes no RAM byte.
- R5: Only the first `err_count` entries are used. Entry k sits in bits [13k+12:13k] of `err_locs`. The entries are applied in order 0, 1, 2, …, and each flip sees the result of the flips before it, so a location listed twice leaves its byte unchanged.
- R6: A start with `err_count` = 0 gives `done` high in the cycle after the start edge, with `busy` staying low and no RAM write.
- R7: After the start edge, an in-range entry takes two cycles and a dropped entry takes one. Over a list whose total is N cycles, `busy` is high for N cycles. `done` is then high for exactly one cycle with `busy` low.
- R8: A `start` seen while `busy` is high is ignored. Its count and locations do not change the list in progress.
- R9: `host_rd_data` shows the byte at `host_addr` one cycle after the address is presented. Host writes made while `busy` is high are ignored.
- R10: An `err_count` above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins processing the list; sampled only while idle |
| err_count | input | 4 | Number of valid list entries (0 to 8; larger values act as 8) |
| err_locs | input | 104 | Eight 13-bit error locations; entry k in bits [13k+12:13k] |
| busy | output | 1 | The list is being applied and the engine owns the RAM |
| done | output | 1 | One-cycle pulse after the last entry |
| host_wr_en | input | 1 | Byte write into the sector RAM (ignored while busy) |
| host_addr | input | 9 | Byte address for host reads and writes |
| host_wr_data | input | 8 | Byte to write |
| host_rd_data | output | 8 | Registered RAM read data |

## Verification
The assertions assume that the locations, the count and the start strobe come from a well-behaved locator. They expect a start only while idle, or else they expect the start to be ignored. They also assume the host never reads the RAM while `busy` is high, because the read port then shows the engine's own reads. The stimulus loads the sector only while idle and issues each list from idle. It makes one deliberate overlap, a second start plus a host write placed inside a running list, to exercise R8 and R9. The locations cover the exact parity boundary, both ends of the sector, out-of-range values, duplicates, entries past the count and an oversized count.

// File: rtl/bch_flip_pkg.sv
package bch_flip_pkg;

  // Sequencer states for the flip engine.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FLIP = 2'd2
  } flip_state_e;

endpackage

// File: rtl/bch_loc_map.sv
// Maps one locator index onto a sector byte address and a one-hot bit mask.
module bch_loc_map #(
  parameter int LOC_W        = 13,
  parameter int NIBBLES      = 26,
  parameter int SECTOR_BYTES = 512,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
  input  logic [LOC_W-1:0]  loc,
  output logic              hit,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        bit_mask
);

  localparam int PARITY_BITS = NIBBLES * 4;
  localparam int SECTOR_BITS = SECTOR_BYTES * 8;
  localparam int AW          = LOC_W + 1;

  localparam logic [AW-1:0] PARITY_V = AW'(PARITY_BITS);
  localparam logic [AW-1:0] SPAN_V   = AW'(SECTOR_BITS);
  localparam logic [AW-1:0] TOP_V    = AW'(SECTOR_BITS - 1);

  logic [AW-1:0] loc_w;
  logic [AW-1:0] adj;
  logic [AW-1:0] mirror;
  logic          above_parity;
  logic          inside_sector;
  logic          unused_mirror_bits;

  always_comb begin
    loc_w         = {1'b0, loc};
    adj           = loc_w - PARITY_V;
    above_parity  = (loc_w >= PARITY_V);
    inside_sector = (adj < SPAN_V);
    hit           = above_parity && inside_sector;
    mirror        = TOP_V - adj;
    byte_addr     = mirror[ADDR_W+2:3];
    bit_mask      = 8'd1 << adj[2:0];
  end

  assign unused_mirror_bits = ^{mirror[AW-1:ADDR_W+3], mirror[2:0]};

endmodule

// File: rtl/sector_ram.sv
// Single-port byte RAM with a registered read.
module sector_ram #(
  parameter int DEPTH  = 512,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[addr];
  end

endmodule

// File: rtl/bch_flip_ctrl.sv
// Walks the location list and issues read-modify-write flips.
module bch_flip_ctrl
  import bch_flip_pkg::*;
#(
  parameter int MAX_ERR      = 8,
  parameter int LOC_W        = 13,
  parameter int CNT_W        = 4,
  parameter int NIBBLES      = 26,
  parameter int SECTOR_BYTES = 512,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES),
  localparam int IDX_W       = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [CNT_W-1:0]         err_count,
  input  logic [MAX_ERR*LOC_W-1:0] err_locs,
  input  logic [7:0]               ram_rdata,
  output logic                     busy,
  output logic                     done,
  output logic                     eng_rd,
  output logic                     eng_we,
  output logic [ADDR_W-1:0]        eng_addr,
  output logic [7:0]               eng_wdata,
  output logic [7:0]               eng_mask
);

  flip_state_e       state;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last_idx;
  logic              done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        mask_q;
  logic [CNT_W-1:0]  n_eff;

  logic [LOC_W-1:0]  loc_in [MAX_ERR];
  logic [LOC_W-1:0]  loc_q  [MAX_ERR];

  logic              map_hit;
  logic [ADDR_W-1:0] map_addr;
  logic [7:0]        map_mask;

  for (genvar g = 0; g < MAX_ERR; g++) begin : g_unpack
    assign loc_in[g] = err_locs[g*LOC_W +: LOC_W];
  end

  always_comb begin
    if (err_count > CNT_W'(MAX_ERR)) n_eff = CNT_W'(MAX_ERR);
    else                              n_eff = err_count;
  end

  bch_loc_map #(
    .LOC_W        (LOC_W),
    .NIBBLES      (NIBBLES),
    .SECTOR_BYTES (SECTOR_BYTES)
  ) u_map (
    .loc       (loc_q[idx]),
    .hit       (map_hit),
    .byte_addr (map_addr),
    .bit_mask  (map_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      last_idx <= '0;
      done_q   <= 1'b0;
      addr_q   <= '0;
      mask_q   <= '0;
      for (int i = 0; i < MAX_ERR; i++) loc_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            for (int i = 0; i < MAX_ERR; i++) loc_q[i] <= loc_in[i];
            if (n_eff == '0) begin
              done_q <= 1'b1;
            end else begin
              state    <= ST_SCAN;
              idx      <= '0;
              last_idx <= IDX_W'(n_eff - 1'b1);
            end
          end
        end
        ST_SCAN: begin
          if (map_hit) begin
            addr_q <= map_addr;
            mask_q <= map_mask;
            state  <= ST_FLIP;
          end else if (idx == last_idx) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_FLIP: begin
          if (idx == last_idx) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_SCAN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign eng_rd    = (state == ST_SCAN) && map_hit;
  assign eng_we    = (state == ST_FLIP);
  assign eng_addr  = eng_we ? addr_q : map_addr;
  assign eng_wdata = ram_rdata ^ mask_q;
  assign eng_mask  = mask_q;

  // R7: done lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: done arrives with the engine idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state == ST_IDLE));

  // R6: empty list finishes at once without leaving idle
  a_r6_empty_list: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && start && (err_count == '0)) |=> (done_q && (state == ST_IDLE)));

  // R5: each write is preceded by the read of the same entry
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLIP) |-> $past(eng_rd));

  // R8: a start during a running list leaves the list length alone
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != ST_IDLE) && start) |=> $stable(last_idx));

endmodule

// File: rtl/bch_err_flipper.sv
// Top: sector RAM plus location-driven bit flip engine.
module bch_err_flipper #(
  parameter int MAX_ERR      = 8,
  parameter int LOC_W        = 13,
  parameter int NIBBLES      = 26,
  parameter int SECTOR_BYTES = 512,
  localparam int CNT_W       = $clog2(MAX_ERR + 1),
  localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [CNT_W-1:0]         err_count,
  input  logic [MAX_ERR*LOC_W-1:0] err_locs,
  output logic                     busy,
  output logic                     done,
  input  logic                     host_wr_en,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [7:0]               host_wr_data,
  output logic [7:0]               host_rd_data
);

  logic              eng_rd;
  logic              eng_we;
  logic [ADDR_W-1:0] eng_addr;
  logic [7:0]        eng_wdata;
  logic [7:0]        eng_mask;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [7:0]        ram_wdata;
  logic [7:0]        ram_rdata;

  bch_flip_ctrl #(
    .MAX_ERR      (MAX_ERR),
    .LOC_W        (LOC_W),
    .CNT_W        (CNT_W),
    .NIBBLES      (NIBBLES),
    .SECTOR_BYTES (SECTOR_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .err_count (err_count),
    .err_locs  (err_locs),
    .ram_rdata (ram_rdata),
    .busy      (busy),
    .done      (done),
    .eng_rd    (eng_rd),
    .eng_we    (eng_we),
    .eng_addr  (eng_addr),
    .eng_wdata (eng_wdata),
    .eng_mask  (eng_mask)
  );

  always_comb begin
    if (busy) begin
      ram_we    = eng_we;
      ram_addr  = eng_addr;
      ram_wdata = eng_wdata;
    end else begin
      ram_we    = host_wr_en;
      ram_addr  = host_addr;
      ram_wdata = host_wr_data;
    end
  end

  sector_ram #(.DEPTH(SECTOR_BYTES)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  assign host_rd_data = ram_rdata;

  // R3: every engine write inverts exactly one bit
  a_r3_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> ($countones(eng_mask) == 1));

  // R3: the write goes to the byte that was read the cycle before
  a_r3_same_byte: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> (eng_addr == $past(eng_addr)));

  // R9: the host never reaches the RAM while the engine is busy
  a_r9_host_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_we) |-> !ram_we);

endmodule

// File: tb/tb_bch_err_flipper.sv
module tb_bch_err_flipper;

  localparam int NLOC = 8;
  localparam int LW   = 13;
  localparam int PAR  = 104;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [3:0]       err_count = '0;
  logic [NLOC*LW-1:0] err_locs = '0;
  logic             busy;
  logic             done;
  logic             host_wr_en = 1'b0;
  logic [8:0]       host_addr = '0;
  logic [7:0]       host_wr_data = '0;
  logic [7:0]       host_rd_data;

  int total = 0;
  int bad   = 0;
  int ref_mem [512];

  always #10 clk = ~clk;

  bch_err_flipper dut (
    .clk(clk), .rst_n(rst_n), .start(start), .err_count(err_count),
    .err_locs(err_locs), .busy(busy), .done(done),
    .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wr_data(host_wr_data), .host_rd_data(host_rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NLOC*LW-1:0] pack(input int l[NLOC]);
    logic [NLOC*LW-1:0] v = '0;
    for (int i = 0; i < NLOC; i++) v[i*LW +: LW] = LW'(l[i]);
    return v;
  endfunction

  // Applies a list to the reference copy, returns the expected busy cycles.
  function automatic int model_list(input int cnt, input int l[NLOC]);
    int n = (cnt > NLOC) ? NLOC : cnt;
    int cyc = 0;
    for (int i = 0; i < n; i++) begin
      if (l[i] >= PAR && (l[i] - PAR) < 4096) begin
        int a = l[i] - PAR;
        ref_mem[(4095 - a) / 8] ^= (1 << (a % 8));
        cyc += 2;
      end else begin
        cyc += 1;
      end
    end
    return cyc;
  endfunction

  task automatic verify_ram(input string req);
    int miss = 0;
    int first_a = -1;
    int first_v = 0;
    for (int a = 0; a < 512; a++) begin
      host_addr = 9'(a);
      @(negedge clk);
      if (int'(host_rd_data) != ref_mem[a]) begin
        if (first_a < 0) begin first_a = a; first_v = int'(host_rd_data); end
        miss++;
      end
    end
    if (first_a < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, {req, " ram byte"}, first_v, ref_mem[first_a]);
  endtask

  task automatic run_list(input string req, input int cnt, input int l[NLOC],
                          input bit overlap);
    int n_cyc;
    int alt[NLOC] = '{PAR, PAR, PAR+1, PAR+2, PAR+3, PAR+4, PAR+5, PAR+6};
    n_cyc = model_list(cnt, l);
    start     = 1'b1;
    err_count = 4'(cnt);
    err_locs  = pack(l);
    @(negedge clk);
    if (overlap) begin
      // R8 and R9: second start and a host write inside a running list
      err_count    = 4'd8;
      err_locs     = pack(alt);
      host_wr_en   = 1'b1;
      host_addr    = 9'd3;
      host_wr_data = 8'hAA;
    end else begin
      start = 1'b0;
    end
    for (int k = 0; k <= n_cyc; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 1) begin
        start      = 1'b0;
        host_wr_en = 1'b0;
      end
      chk(busy == (k < n_cyc), {req, " R7 busy"}, busy, k < n_cyc);
      chk(done == (k == n_cyc), {req, " R7 done"}, done, k == n_cyc);
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, {req, " R7 after"}, {busy, done}, 0);
    verify_ram(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int l1[NLOC] = '{104, 0, 0, 0, 0, 0, 0, 0};
    int l2[NLOC] = '{103, 0, 4199, 0, 0, 0, 0, 0};
    int l3[NLOC] = '{4200, 8191, 0, 0, 0, 0, 0, 0};
    int l4[NLOC] = '{200, 200, 1000, 2000, 3000, 4100, 50, 500};
    int l5[NLOC] = '{300, 301, 302, 303, 400, 401, 402, 403};
    int l6[NLOC] = '{900, 901, 0, 0, 0, 0, 0, 0};
    int l7[NLOC] = '{111, 222, 333, 444, 555, 666, 777, 888};
    int l8[NLOC] = '{600, 700, 800, 0, 0, 0, 0, 0};

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(host_rd_data == 8'h00, "R1 rd_data", host_rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 after release", {busy, done}, 0);

    for (int a = 0; a < 512; a++) begin
      ref_mem[a]   = (a * 37 + 5) & 255;
      host_wr_en   = 1'b1;
      host_addr    = 9'(a);
      host_wr_data = 8'(ref_mem[a]);
      @(negedge clk);
    end
    host_wr_en = 1'b0;
    // R9: host read latency of one cycle
    host_addr = 9'd77;
    @(negedge clk);
    chk(int'(host_rd_data) == ref_mem[77], "R9 read latency", host_rd_data, ref_mem[77]);

    run_list("R3 first data bit", 1, l1, 1'b0);
    run_list("R2 R3 boundary", 3, l2, 1'b0);
    run_list("R4 beyond sector", 2, l3, 1'b0);
    run_list("R5 order dup", 8, l4, 1'b0);
    run_list("R5 count limit", 4, l5, 1'b0);
    run_list("R6 empty", 0, l6, 1'b0);
    run_list("R10 clamp", 12, l7, 1'b0);
    run_list("R8 R9 overlap", 3, l8, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule